// File: doc/BRIEF.md
# Flash Status Auto-Polling Engine

This block repeatedly reads a status word from an external serial flash until that word satisfies a masked comparison. It does not drive the serial wires. It sits above a command engine: it raises a one-cycle read request that carries the number of status bytes wanted, and it takes the bytes back one per cycle on a response strobe. The bytes are packed into a status word, and the first byte lands in bits 7:0. After each complete read the word is compared against a match value under a mask. Only the bytes actually read take part in the comparison. The engine then either stops, or waits a programmed number of cycles and reads again.

Two compare modes exist. In conjunction mode every selected bit must equal its match bit. In disjunction mode one equal selected bit is enough. A match sets a sticky flag that stays set until a clear strobe. With auto-stop on, the first match ends polling. With auto-stop off, polling runs until an abort. An abort that arrives while a read is in progress waits for that read to finish and then drops the read without comparing it.

The controller has five states:
- IDLE: goes to ISSUE on `start`.
- ISSUE: drives the request for one cycle and goes to COLLECT.
- COLLECT: counts the returned bytes. After the last byte it goes to EVAL, or to IDLE if an abort is pending.
- EVAL: compares the word and updates the flag and the status output. It goes to IDLE on an abort or on a match with auto-stop on. Otherwise it goes to ISSUE when the interval is zero and to GAP when it is not.
- GAP: counts the interval. It goes to IDLE on an abort and to ISSUE when the count expires.

Top module: `status_poll_engine`

## Requirements
- R1: After reset, `busy`, `rd_req` and `match_flag` are 0 and `status_word` is 0. A `start` pulse in idle makes `rd_req` high for exactly one cycle, in the next cycle, with `rd_len` equal to `cfg_size`. `busy` is high from that cycle until polling ends.
- R2: The bytes of a read are packed with the first byte in bits 7:0, the second in 15:8, and so on. Byte positions beyond the programmed size read as zero. `status_word` takes the new word at the end of the cycle after the last byte.
- R3: `cfg_size` codes 0, 1, 2 and 3 select 1, 2, 3 and 4 bytes. Mismatches in bytes that were not read never affect the result.
- R4: With `cfg_or_mode`=0, a read matches when every compared bit that has its `cfg_mask` bit set equals its `cfg_match` bit. An all-zero mask therefore always matches.
- R5: With `cfg_or_mode`=1, a read matches when at least one compared bit that has its mask bit set equals its match bit. An all-zero mask therefore never matches.
- R6: Call the cycle of the last byte k. When polling continues, the next `rd_req` occurs in cycle k+2+`cfg_interval`.
- R7: With `cfg_auto_stop`=1, a match sets `match_flag` and drops `busy` at the same edge, at the end of cycle k+1. No further request follows.
- R8: With `cfg_auto_stop`=0, a match sets `match_flag` and polling carries on with the next read.
- R9: `match_flag` stays 1 across later reads that do not match and across idle time. It returns to 0 at the edge that samples `flag_clr` high.
- R10: An `abort` seen during ISSUE or COLLECT lets the read finish. `busy` then falls at the end of cycle k. `match_flag` and `status_word` keep their previous values, and no new request follows.
- R11: An `abort` during GAP drops `busy` at the next edge, and no new request follows.
- R12: A `start` pulse while `busy` is high has no effect on the request timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin polling (honoured only when idle) |
| abort | input | 1 | Stop polling |
| flag_clr | input | 1 | Clear the match flag |
| cfg_match | input | 32 | Value the status is compared against |
| cfg_mask | input | 32 | 1 marks a bit that is compared |
| cfg_or_mode | input | 1 | 0 = all selected bits equal, 1 = any selected bit equal |
| cfg_interval | input | 16 | Idle cycles between reads |
| cfg_size | input | 2 | Status bytes per read minus one |
| cfg_auto_stop | input | 1 | Stop on the first match |
| rd_req | output | 1 | One-cycle read request to the command engine |
| rd_len | output | 2 | Bytes requested minus one |
| rsp_valid | input | 1 | A status byte is present |
| rsp_data | input | 8 | Status byte |
| busy | output | 1 | Polling in progress |
| match_flag | output | 1 | Sticky status-match flag |
| status_word | output | 32 | Last status word compared |

## Verification
The bench sweeps every byte size in both compare modes. It uses patterns whose only mismatch lies in bytes that were not read, patterns with one flipped bit, and random values. A design that compared the whole 32-bit word, or that reversed the byte order, would report wrong match results there. An all-zero mask is tried in both modes, which catches a disjunction compare that treats "no selected bits" as a match. The request gap is measured for intervals from 1 up to several hundred cycles, so an off-by-one in the interval counter shows up directly. An abort is placed in the middle of a matching read; a design that compared the aborted read would set the flag or change the status word.

// File: rtl/poll_pkg.sv
package poll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_COLLECT,
        ST_EVAL,
        ST_GAP
    } poll_state_e;
endpackage

// File: rtl/poll_match_unit.sv
// Masked status comparison restricted to the bytes actually read.
module poll_match_unit #(
    parameter int NB   = 4,
    parameter int SZ_W = $clog2(NB)
) (
    input  logic [NB*8-1:0] word,
    input  logic [NB*8-1:0] ref_val,
    input  logic [NB*8-1:0] mask,
    input  logic [SZ_W-1:0] size,
    input  logic            or_mode,
    output logic            hit
);
    logic [NB*8-1:0] size_mask;
    logic [NB*8-1:0] sel;
    logic [NB*8-1:0] same;

    for (genvar b = 0; b < NB; b++) begin : g_bytes
        assign size_mask[b*8 +: 8] = (size >= SZ_W'(b)) ? 8'hFF : 8'h00;
    end

    always_comb begin
        sel  = mask & size_mask;
        same = ~(word ^ ref_val);
        if (or_mode) hit = |(same & sel);
        else         hit = ((~same & sel) == '0);
    end
endmodule

// File: rtl/poll_gap_timer.sv
// Counts the idle cycles between two status reads.
module poll_gap_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= W'(1);
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= W'(1);
    end

    assign done = run && (cnt == limit);

    p_gap_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= limit))
        else $error("gap counter passed its limit");
endmodule

// File: rtl/status_poll_engine.sv
module status_poll_engine
    import poll_pkg::*;
#(
    parameter int STAT_BYTES = 4,
    parameter int GAP_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    abort,
    input  logic                    flag_clr,
    input  logic [STAT_BYTES*8-1:0] cfg_match,
    input  logic [STAT_BYTES*8-1:0] cfg_mask,
    input  logic                    cfg_or_mode,
    input  logic [GAP_W-1:0]        cfg_interval,
    input  logic [$clog2(STAT_BYTES)-1:0] cfg_size,
    input  logic                    cfg_auto_stop,
    output logic                    rd_req,
    output logic [$clog2(STAT_BYTES)-1:0] rd_len,
    input  logic                    rsp_valid,
    input  logic [7:0]              rsp_data,
    output logic                    busy,
    output logic                    match_flag,
    output logic [STAT_BYTES*8-1:0] status_word
);
    localparam int STAT_W = STAT_BYTES * 8;
    localparam int SZ_W   = $clog2(STAT_BYTES);

    poll_state_e     state, nxt;
    logic [SZ_W-1:0] idx;
    logic [STAT_W-1:0] shadow;
    logic            abort_pend;
    logic            last_byte;
    logic            hit;
    logic            gap_done;

    assign last_byte = rsp_valid && (idx == cfg_size);

    poll_match_unit #(.NB(STAT_BYTES), .SZ_W(SZ_W)) u_match (
        .word    (shadow),
        .ref_val (cfg_match),
        .mask    (cfg_mask),
        .size    (cfg_size),
        .or_mode (cfg_or_mode),
        .hit     (hit)
    );

    poll_gap_timer #(.W(GAP_W)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_GAP),
        .limit (cfg_interval),
        .done  (gap_done)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_ISSUE;
            ST_ISSUE:   nxt = ST_COLLECT;
            ST_COLLECT: if (last_byte) nxt = (abort_pend || abort) ? ST_IDLE : ST_EVAL;
            ST_EVAL: begin
                if (abort)                      nxt = ST_IDLE;
                else if (hit && cfg_auto_stop)  nxt = ST_IDLE;
                else if (cfg_interval == '0)    nxt = ST_ISSUE;
                else                            nxt = ST_GAP;
            end
            ST_GAP: begin
                if (abort)         nxt = ST_IDLE;
                else if (gap_done) nxt = ST_ISSUE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register and read datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            idx        <= '0;
            shadow     <= '0;
            abort_pend <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE)
                abort_pend <= 1'b0;
            else if (abort && (state == ST_ISSUE || state == ST_COLLECT))
                abort_pend <= 1'b1;
            if (state == ST_ISSUE) begin
                idx    <= '0;
                shadow <= '0;
            end else if (state == ST_COLLECT && rsp_valid) begin
                idx <= idx + 1'b1;
                shadow[int'(idx)*8 +: 8] <= rsp_data;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_flag  <= 1'b0;
            status_word <= '0;
        end else begin
            if (state == ST_EVAL) status_word <= shadow;
            if (state == ST_EVAL && hit) match_flag <= 1'b1;
            else if (flag_clr)           match_flag <= 1'b0;
        end
    end

    assign rd_req = (state == ST_ISSUE);
    assign rd_len = cfg_size;
    assign busy   = (state != ST_IDLE);

    p_req_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req)
        else $error("request longer than one cycle");

    p_autostop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(match_flag) && $past(cfg_auto_stop) && !$past(abort_pend)) |-> !busy)
        else $error("still busy after a match with auto-stop");

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !flag_clr) |=> match_flag)
        else $error("match flag dropped without clear");

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(match_flag) |-> $past(flag_clr))
        else $error("match flag fell with no clear");

    p_abort_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COLLECT && last_byte && (abort_pend || abort)) |=> !busy)
        else $error("aborted read was not dropped");
endmodule

// File: tb/sim_status_poll_engine.sv
module sim_status_poll_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abort = 1'b0, flag_clr = 1'b0;
    logic [31:0] cfg_match = '0, cfg_mask = '0;
    logic        cfg_or_mode = 1'b0, cfg_auto_stop = 1'b1;
    logic [15:0] cfg_interval = 16'd3;
    logic [1:0]  cfg_size = 2'd0;
    logic        rd_req;
    logic [1:0]  rd_len;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_data = '0;
    logic        busy, match_flag;
    logic [31:0] status_word;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    status_poll_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .flag_clr(flag_clr),
        .cfg_match(cfg_match), .cfg_mask(cfg_mask), .cfg_or_mode(cfg_or_mode),
        .cfg_interval(cfg_interval), .cfg_size(cfg_size), .cfg_auto_stop(cfg_auto_stop),
        .rd_req(rd_req), .rd_len(rd_len), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .busy(busy), .match_flag(match_flag), .status_word(status_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed ^ (seed >> 13);
    endfunction

    function automatic logic [31:0] size_bits(input logic [1:0] sz);
        return (sz == 2'd3) ? 32'hFFFF_FFFF : ((32'd1 << ((32'(sz) + 1) * 8)) - 1);
    endfunction

    function automatic logic exp_hit(input logic [31:0] w, m, k, input logic [1:0] sz, input logic orm);
        logic [31:0] sel, eq;
        sel = k & size_bits(sz);
        eq  = ~(w ^ m);
        return orm ? (|(eq & sel)) : (((~eq) & sel) == 32'd0);
    endfunction

    task automatic go();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic wait_req(output int gap);
        gap = 0;
        while (!rd_req && gap < 1000) begin
            @(negedge clk);
            gap++;
        end
    endtask

    // Feeds the bytes starting in the cycle after the request; returns in cycle k+2.
    task automatic deliver(input logic [31:0] w, input logic [1:0] sz);
        for (int b = 0; b <= int'(sz); b++) begin
            @(negedge clk);
            rsp_valid = 1'b1;
            rsp_data  = w[b*8 +: 8];
        end
        @(negedge clk) rsp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic abort_gap(input string tag);
        abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        chk(tag, 32'(busy), 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int g;
        logic [31:0] w, prev;
        logic e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset busy", 32'(busy), 0);
        chk("R1 reset req", 32'(rd_req), 0);
        chk("R1 reset flag", 32'(match_flag), 0);
        chk("R1 reset status", status_word, 0);

        // Compare sweep: sizes x modes x patterns, auto-stop on, interval 3
        cfg_auto_stop = 1'b1;
        cfg_interval  = 16'd3;
        for (int sz = 0; sz < 4; sz++) begin
            for (int om = 0; om < 2; om++) begin
                for (int p = 0; p < 12; p++) begin
                    cfg_size    = 2'(sz);
                    cfg_or_mode = om[0];
                    w         = nxt_rand();
                    cfg_mask  = nxt_rand();
                    case (p % 3)
                        0: cfg_match = w ^ (nxt_rand() & ~size_bits(2'(sz))); // R3
                        1: cfg_match = w ^ (32'd1 << (nxt_rand() % 32));
                        default: cfg_match = nxt_rand();
                    endcase
                    e = exp_hit(w, cfg_match, cfg_mask, 2'(sz), om[0]);
                    clear_flag();
                    go();
                    chk("R1 request", 32'(rd_req), 1);
                    chk("R1 length", 32'(rd_len), 32'(sz));
                    chk("R1 busy", 32'(busy), 1);
                    deliver(w, 2'(sz));
                    chk("R2 status packing", status_word, w & size_bits(2'(sz)));
                    if (p % 3 == 0) chk("R3 unread bytes ignored", 32'(match_flag), 32'(e));
                    else if (om == 1) chk("R5 or compare", 32'(match_flag), 32'(e));
                    else chk("R4 and compare", 32'(match_flag), 32'(e));
                    if (e) begin
                        chk("R7 auto stop busy", 32'(busy), 0);
                        repeat (3) @(negedge clk);
                        chk("R7 no further request", 32'(rd_req | busy), 0);
                    end else begin
                        abort_gap("R11 abort in gap");
                    end
                end
            end
        end

        // Zero mask in both modes
        cfg_mask = '0; cfg_size = 2'd3; cfg_match = 32'hA5A5_A5A5;
        for (int om = 0; om < 2; om++) begin
            cfg_or_mode = om[0];
            clear_flag();
            go();
            deliver(32'h0F0F_0F0F, 2'd3);
            if (om == 0) chk("R4 zero mask matches", 32'(match_flag), 1);
            else begin
                chk("R5 zero mask never matches", 32'(match_flag), 0);
                abort_gap("R11 abort in gap");
            end
        end

        // Interval sweep: never-matching configuration, auto-stop off
        cfg_auto_stop = 1'b0; cfg_or_mode = 1'b1; cfg_mask = '0; cfg_size = 2'd1;
        for (int i = 0; i < 5; i++) begin
            case (i)
                0: cfg_interval = 16'd1;
                1: cfg_interval = 16'd2;
                2: cfg_interval = 16'd5;
                3: cfg_interval = 16'd17;
                default: cfg_interval = 16'd300;
            endcase
            go();
            deliver(32'h0000_1234, 2'd1);
            wait_req(g);
            chk("R6 request gap", 32'(g), 32'(cfg_interval));
            deliver(32'h0000_5678, 2'd1);
            abort_gap("R11 abort in gap");
            @(negedge clk);
            chk("R11 no request after abort", 32'(rd_req), 0);
        end

        // Start while busy is ignored
        cfg_interval = 16'd4;
        go();
        deliver(32'h0000_0001, 2'd1);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_req(g);
        chk("R12 start while busy", 32'(g + 1), 4);
        deliver(32'h0000_0002, 2'd1);
        abort_gap("R11 abort in gap");

        // Auto-stop off keeps polling after a match; flag is sticky
        clear_flag();
        cfg_or_mode = 1'b0; cfg_mask = '0; cfg_interval = 16'd2; cfg_size = 2'd2;
        go();
        deliver(32'h00C0_FFEE, 2'd2);
        chk("R8 flag on match", 32'(match_flag), 1);
        chk("R8 still busy", 32'(busy), 1);
        wait_req(g);
        chk("R8 polling continues", 32'(g), 2);
        cfg_or_mode = 1'b1; // zero mask in OR mode: this read does not match
        deliver(32'h0011_2233, 2'd2);
        chk("R9 flag sticky over miss", 32'(match_flag), 1);
        abort_gap("R11 abort in gap");
        repeat (5) @(negedge clk);
        chk("R9 flag sticky when idle", 32'(match_flag), 1);
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk("R9 flag cleared", 32'(match_flag), 0);

        // Abort during a read that would match
        prev = status_word;
        cfg_or_mode = 1'b0; cfg_mask = '0; cfg_auto_stop = 1'b1;
        cfg_interval = 16'd0; cfg_size = 2'd0;
        go();
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        rsp_valid = 1'b1;
        rsp_data  = 8'h5A;
        @(negedge clk) rsp_valid = 1'b0;
        chk("R10 busy falls after aborted read", 32'(busy), 0);
        chk("R10 flag unchanged", 32'(match_flag), 0);
        chk("R10 status unchanged", status_word, prev);
        repeat (4) @(negedge clk);
        chk("R10 no request after abort", 32'(rd_req | busy), 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule